// File: doc/BRIEF.md
# PCI Function Base Address Register Unit

This block is the address-window part of one PCI function's configuration space. It holds four base address registers, each 32 bits wide with a fixed power-of-two size: a prefetchable memory window, an I/O window, a non-prefetchable memory window and an expansion ROM window. It also holds the two decode-enable bits of the command register. Configuration software reads and writes these registers by dword index. To size a window, software writes all ones to a register and reads back the mask. It then programs a base address aligned to that size.

On the bus side, the block compares every incoming address with each programmed window. It raises one hit line per window. A memory window answers only memory-space cycles while memory decode is enabled. The I/O window answers only I/O-space cycles while I/O decode is enabled. The ROM window also needs its own enable bit. The read path and the hit lines are combinational. Register writes take effect at the next rising clock edge.

Top module: `pcibar_unit`

## Requirements
- R1: While reset is asserted and right after it, every register reads back only its hardwired type bits: index 4 reads 0x00000008, index 5 reads 0x00000001, indices 1, 6 and 12 read 0x00000000, and no hit line is high.
- R2: The prefetchable memory window sits at dword index 4 and is 128 MiB by default. After an all-ones write it reads 0xF8000008. Bit 3 = 1 marks it prefetchable and bits 2:1 = 00 mark a 32-bit memory window.
- R3: The I/O window sits at index 5 and is 256 bytes by default. After an all-ones write it reads 0xFFFFFF01. Bit 0 = 1 marks I/O space and bit 1 reads 0.
- R4: The non-prefetchable memory window sits at index 6 and is 64 KiB by default. After an all-ones write it reads 0xFFFF0000.
- R5: The ROM window sits at index 12 and is 128 KiB by default. After an all-ones write it reads 0xFFFE0001. Bit 0 is a writable ROM-decode enable.
- R6: Address bits below a window's size boundary read as zero. Any value written to them is discarded. For example, writing 0x12345677 to index 4 reads back 0x10000008.
- R7: Each write byte-enable bit i gates data bits 8i+7:8i. Bytes whose enable is low keep their old value, and a write with no byte enable changes nothing.
- R8: The command register sits at index 1. Bit 0 is I/O decode enable and bit 1 is memory decode enable, both in byte lane 0. Every other bit reads 0. Clearing both bits drops all hit lines from the next cycle.
- R9: A memory window's hit line is high exactly when `bus_io_space` is 0, memory decode is enabled, and the address masked to the window size equals the programmed base.
- R10: The I/O window's hit line is high exactly when `bus_io_space` is 1, I/O decode is enabled, and the masked address equals the I/O base.
- R11: The ROM hit line needs everything a memory hit needs, and in addition the ROM enable bit (index 12, bit 0) must be set.
- R12: A write to any index other than 1, 4, 5, 6 or 12 changes no state, and reads of such indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Dword register index for reads and writes |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_idx` |
| bus_addr | input | 32 | Incoming bus address |
| bus_io_space | input | 1 | 1 for an I/O-space cycle, 0 for a memory-space cycle |
| hit_pref | output | 1 | Prefetchable memory window hit |
| hit_io | output | 1 | I/O window hit |
| hit_np | output | 1 | Non-prefetchable memory window hit |
| hit_rom | output | 1 | Expansion ROM window hit |

## Verification
Some properties must hold on every cycle, and the assertions check those. They cover the hardwired type bits and zero low bits on every read of the sized registers. They cover that each hit line matches its address space and the enable bits that gate it. They also cover that a write with no byte enable, or to an unmapped index, leaves all state unchanged, and that clearing the command bits silences decode on the next cycle. Only the bench's scenarios can show the exact read-back values after sizing, how byte lanes merge, and which window answers an address just inside or just outside its boundary.

// File: rtl/pcibar_pkg.sv
package pcibar_pkg;

    typedef enum logic [1:0] {
        BK_MEM_PF = 2'd0,
        BK_IO     = 2'd1,
        BK_MEM_NP = 2'd2,
        BK_ROM    = 2'd3
    } bar_kind_e;

    localparam int NUM_SLOTS = 4;

    // Dword indices decoded by configuration software; fixed by convention.
    localparam logic [5:0] IDX_CMD  = 6'd1;
    localparam logic [5:0] IDX_PREF = 6'd4;
    localparam logic [5:0] IDX_IO   = 6'd5;
    localparam logic [5:0] IDX_NP   = 6'd6;
    localparam logic [5:0] IDX_ROM  = 6'd12;

    // Command bits: bit 1 memory decode, bit 0 I/O decode.
    typedef struct packed {
        logic mem_en;
        logic io_en;
    } cmd_t;

    function automatic bar_kind_e slot_kind(input int s);
        case (s)
            0:       return BK_MEM_PF;
            1:       return BK_IO;
            2:       return BK_MEM_NP;
            default: return BK_ROM;
        endcase
    endfunction

    function automatic logic [5:0] slot_index(input int s);
        case (s)
            0:       return IDX_PREF;
            1:       return IDX_IO;
            2:       return IDX_NP;
            default: return IDX_ROM;
        endcase
    endfunction

    // Hardwired low bits that describe the window type.
    function automatic logic [31:0] type_bits(input bar_kind_e k);
        case (k)
            BK_MEM_PF: return 32'h0000_0008;
            BK_IO:     return 32'h0000_0001;
            default:   return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input int lg);
        return 32'hFFFF_FFFF << lg;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/pcibar_slot.sv
module pcibar_slot
    import pcibar_pkg::*;
#(
    parameter bar_kind_e KIND    = BK_MEM_NP,
    parameter int        SIZE_LG = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [31:0] base,
    output logic        rom_on
);

    localparam logic [31:0] MASK    = size_mask(SIZE_LG);
    localparam logic [31:0] TYPE    = type_bits(KIND);
    localparam logic        HAS_EN  = (KIND == BK_ROM);

    typedef struct packed {
        logic [31:0] base;
        logic        en;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic [31:0] merged;
    logic [31:0] lanes;

    always_comb begin
        st_d   = st_q;
        lanes  = lane_mask(be);
        merged = (rdata & ~lanes) | (wdata & lanes);
        if (wr_sel) begin
            st_d.base = merged & MASK;
            st_d.en   = HAS_EN & merged[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.base | TYPE | {31'b0, HAS_EN & st_q.en};
    assign base   = st_q.base;
    assign rom_on = HAS_EN & st_q.en;

endmodule

// File: rtl/pcibar_match.sv
module pcibar_match #(
    parameter int SIZE_LG = 16
) (
    input  logic [31:0] addr,
    input  logic [31:0] base,
    input  logic        space_ok,
    output logic        hit
);

    localparam logic [31:0] MASK = 32'hFFFF_FFFF << SIZE_LG;

    assign hit = space_ok && ((addr & MASK) == base);

endmodule

// File: rtl/pcibar_unit.sv
module pcibar_unit
    import pcibar_pkg::*;
#(
    parameter int PREF_SIZE_LG = 27,
    parameter int IO_SIZE_LG   = 8,
    parameter int NP_SIZE_LG   = 16,
    parameter int ROM_SIZE_LG  = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_idx,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] bus_addr,
    input  logic        bus_io_space,
    output logic        hit_pref,
    output logic        hit_io,
    output logic        hit_np,
    output logic        hit_rom
);

    cmd_t cmd_d, cmd_q;

    logic [31:0] slot_rd   [NUM_SLOTS];
    logic [31:0] slot_base [NUM_SLOTS];
    logic        slot_en   [NUM_SLOTS];
    logic        slot_hit  [NUM_SLOTS];
    logic [NUM_SLOTS*32-1:0] slot_flat;

    // Command register: only lane 0 carries the two decode enables.
    always_comb begin
        cmd_d = cmd_q;
        if (cfg_wr && cfg_idx == IDX_CMD && cfg_be[0]) begin
            cmd_d.mem_en = cfg_wdata[1];
            cmd_d.io_en  = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam bar_kind_e  K   = slot_kind(g);
        localparam logic [5:0] IDX = slot_index(g);
        localparam int LG = (g == 0) ? PREF_SIZE_LG :
                            (g == 1) ? IO_SIZE_LG   :
                            (g == 2) ? NP_SIZE_LG   : ROM_SIZE_LG;

        logic space_ok;

        pcibar_slot #(
            .KIND    (K),
            .SIZE_LG (LG)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (cfg_wr && cfg_idx == IDX),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .rdata  (slot_rd[g]),
            .base   (slot_base[g]),
            .rom_on (slot_en[g])
        );

        if (K == BK_IO) begin : g_io
            assign space_ok = cmd_q.io_en && bus_io_space;
        end else if (K == BK_ROM) begin : g_rom
            assign space_ok = cmd_q.mem_en && !bus_io_space && slot_en[g];
        end else begin : g_mem
            assign space_ok = cmd_q.mem_en && !bus_io_space;
        end

        pcibar_match #(
            .SIZE_LG (LG)
        ) u_match (
            .addr     (bus_addr),
            .base     (slot_base[g]),
            .space_ok (space_ok),
            .hit      (slot_hit[g])
        );

        assign slot_flat[32*g +: 32] = slot_rd[g];
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_idx == IDX_CMD) begin
            cfg_rdata = {30'b0, cmd_q.mem_en, cmd_q.io_en};
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (cfg_idx == slot_index(s)) begin
                cfg_rdata = slot_rd[s];
            end
        end
    end

    assign hit_pref = slot_hit[0];
    assign hit_io   = slot_hit[1];
    assign hit_np   = slot_hit[2];
    assign hit_rom  = slot_hit[3];

endmodule

// File: rtl/pcibar_checker.sv
module pcibar_checker #(
    parameter int NP_LG = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_wr,
    input logic [5:0]   cfg_idx,
    input logic [3:0]   cfg_be,
    input logic [31:0]  cfg_wdata,
    input logic [31:0]  cfg_rdata,
    input logic         bus_io_space,
    input logic         hit_pref,
    input logic         hit_io,
    input logic         hit_np,
    input logic         hit_rom,
    input logic [1:0]   cmd_bits,
    input logic [127:0] slot_flat
);

    localparam logic [31:0] NP_MASK = 32'hFFFF_FFFF << NP_LG;

    logic unmapped;
    assign unmapped = !(cfg_idx == 6'd1 || cfg_idx == 6'd4 || cfg_idx == 6'd5 ||
                        cfg_idx == 6'd6 || cfg_idx == 6'd12);

    p_pref_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 6'd4) |-> (cfg_rdata[3:0] == 4'h8));

    p_io_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 6'd5) |-> (cfg_rdata[1:0] == 2'b01));

    p_np_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 6'd6) |-> ((cfg_rdata & ~NP_MASK) == 32'h0));

    p_zero_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_be == 4'h0) |=> ($stable(slot_flat) && $stable(cmd_bits)));

    p_cmd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx == 6'd1 && cfg_be[0] && cfg_wdata[1:0] == 2'b00)
        |=> !(hit_pref || hit_io || hit_np || hit_rom));

    p_mem_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pref || hit_np) |-> (!bus_io_space && cmd_bits[1]));

    p_io_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_io |-> (bus_io_space && cmd_bits[0]));

    p_rom_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rom |-> (!bus_io_space && cmd_bits[1] && slot_flat[96]));

    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && unmapped) |=> ($stable(slot_flat) && $stable(cmd_bits)));

    p_unmapped_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (cfg_rdata == 32'h0));

endmodule

bind pcibar_unit pcibar_checker #(
    .NP_LG (NP_SIZE_LG)
) u_pcibar_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_idx      (cfg_idx),
    .cfg_be       (cfg_be),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .bus_io_space (bus_io_space),
    .hit_pref     (hit_pref),
    .hit_io       (hit_io),
    .hit_np       (hit_np),
    .hit_rom      (hit_rom),
    .cmd_bits     (cmd_q),
    .slot_flat    (slot_flat)
);

// File: tb/pcibar_unit_bench.sv
module pcibar_unit_bench;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_HIT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [5:0]  idx;
        logic [3:0]  be;
        logic        io;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // Hit expectations are {rom, np, io, pref}.
    localparam int NV = 61;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,  4'd1,  6'd1,  4'h0, 1'b0, 32'h0,         32'h0000_0000}, // R1
        '{OP_RD,  4'd1,  6'd4,  4'h0, 1'b0, 32'h0,         32'h0000_0008}, // R1
        '{OP_RD,  4'd1,  6'd5,  4'h0, 1'b0, 32'h0,         32'h0000_0001}, // R1
        '{OP_RD,  4'd1,  6'd6,  4'h0, 1'b0, 32'h0,         32'h0000_0000}, // R1
        '{OP_RD,  4'd1,  6'd12, 4'h0, 1'b0, 32'h0,         32'h0000_0000}, // R1
        '{OP_WR,  4'd2,  6'd4,  4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R2
        '{OP_RD,  4'd2,  6'd4,  4'h0, 1'b0, 32'h0,         32'hF800_0008}, // R2
        '{OP_WR,  4'd3,  6'd5,  4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R3
        '{OP_RD,  4'd3,  6'd5,  4'h0, 1'b0, 32'h0,         32'hFFFF_FF01}, // R3
        '{OP_WR,  4'd4,  6'd6,  4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R4
        '{OP_RD,  4'd4,  6'd6,  4'h0, 1'b0, 32'h0,         32'hFFFF_0000}, // R4
        '{OP_WR,  4'd5,  6'd12, 4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R5
        '{OP_RD,  4'd5,  6'd12, 4'h0, 1'b0, 32'h0,         32'hFFFE_0001}, // R5
        '{OP_WR,  4'd6,  6'd4,  4'hF, 1'b0, 32'h1234_5677, 32'h0},         // R6
        '{OP_RD,  4'd6,  6'd4,  4'h0, 1'b0, 32'h0,         32'h1000_0008}, // R6
        '{OP_WR,  4'd6,  6'd5,  4'hF, 1'b0, 32'h0000_ABCD, 32'h0},         // R6
        '{OP_RD,  4'd6,  6'd5,  4'h0, 1'b0, 32'h0,         32'h0000_AB01}, // R6
        '{OP_WR,  4'd6,  6'd6,  4'hF, 1'b0, 32'h80A0_FFFF, 32'h0},         // R6
        '{OP_RD,  4'd6,  6'd6,  4'h0, 1'b0, 32'h0,         32'h80A0_0000}, // R6
        '{OP_WR,  4'd6,  6'd12, 4'hF, 1'b0, 32'h80A2_FFFF, 32'h0},         // R6
        '{OP_RD,  4'd5,  6'd12, 4'h0, 1'b0, 32'h0,         32'h80A2_0001}, // R5
        '{OP_WR,  4'd7,  6'd6,  4'h8, 1'b0, 32'h44FF_FFFF, 32'h0},         // R7
        '{OP_RD,  4'd7,  6'd6,  4'h0, 1'b0, 32'h0,         32'h44A0_0000}, // R7
        '{OP_WR,  4'd7,  6'd6,  4'h4, 1'b0, 32'h0055_0000, 32'h0},         // R7
        '{OP_RD,  4'd7,  6'd6,  4'h0, 1'b0, 32'h0,         32'h4455_0000}, // R7
        '{OP_WR,  4'd7,  6'd6,  4'h3, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R7
        '{OP_RD,  4'd7,  6'd6,  4'h0, 1'b0, 32'h0,         32'h4455_0000}, // R7
        '{OP_WR,  4'd7,  6'd6,  4'hF, 1'b0, 32'h80A0_0000, 32'h0},         // R7
        '{OP_HIT, 4'd9,  6'd0,  4'h0, 1'b0, 32'h1000_0000, 32'h0},         // R9
        '{OP_HIT, 4'd10, 6'd0,  4'h0, 1'b1, 32'h0000_AB00, 32'h0},         // R10
        '{OP_WR,  4'd8,  6'd1,  4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R8
        '{OP_RD,  4'd8,  6'd1,  4'h0, 1'b0, 32'h0,         32'h0000_0003}, // R8
        '{OP_HIT, 4'd9,  6'd0,  4'h0, 1'b0, 32'h17FF_FFFC, 32'h1},         // R9
        '{OP_HIT, 4'd9,  6'd0,  4'h0, 1'b0, 32'h1800_0000, 32'h0},         // R9
        '{OP_HIT, 4'd9,  6'd0,  4'h0, 1'b0, 32'h0FFF_FFFF, 32'h0},         // R9
        '{OP_HIT, 4'd9,  6'd0,  4'h0, 1'b0, 32'h80A0_FFFF, 32'h4},         // R9
        '{OP_HIT, 4'd11, 6'd0,  4'h0, 1'b0, 32'h80A3_FFFF, 32'h8},         // R11
        '{OP_HIT, 4'd10, 6'd0,  4'h0, 1'b1, 32'h0000_AB7F, 32'h2},         // R10
        '{OP_HIT, 4'd10, 6'd0,  4'h0, 1'b0, 32'h0000_AB7F, 32'h0},         // R10
        '{OP_HIT, 4'd10, 6'd0,  4'h0, 1'b1, 32'h80A0_0000, 32'h0},         // R10
        '{OP_HIT, 4'd10, 6'd0,  4'h0, 1'b1, 32'h0000_AC00, 32'h0},         // R10
        '{OP_WR,  4'd11, 6'd12, 4'hF, 1'b0, 32'h80A2_0000, 32'h0},         // R11
        '{OP_RD,  4'd11, 6'd12, 4'h0, 1'b0, 32'h0,         32'h80A2_0000}, // R11
        '{OP_HIT, 4'd11, 6'd0,  4'h0, 1'b0, 32'h80A2_0000, 32'h0},         // R11
        '{OP_WR,  4'd8,  6'd1,  4'h1, 1'b0, 32'h0000_0001, 32'h0},         // R8
        '{OP_RD,  4'd8,  6'd1,  4'h0, 1'b0, 32'h0,         32'h0000_0001}, // R8
        '{OP_HIT, 4'd8,  6'd0,  4'h0, 1'b1, 32'h0000_AB00, 32'h2},         // R8
        '{OP_HIT, 4'd8,  6'd0,  4'h0, 1'b0, 32'h1000_0000, 32'h0},         // R8
        '{OP_WR,  4'd8,  6'd1,  4'h1, 1'b0, 32'h0000_0002, 32'h0},         // R8
        '{OP_HIT, 4'd8,  6'd0,  4'h0, 1'b1, 32'h0000_AB00, 32'h0},         // R8
        '{OP_HIT, 4'd8,  6'd0,  4'h0, 1'b0, 32'h1000_0000, 32'h1},         // R8
        '{OP_WR,  4'd12, 6'd2,  4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R12
        '{OP_RD,  4'd12, 6'd2,  4'h0, 1'b0, 32'h0,         32'h0000_0000}, // R12
        '{OP_WR,  4'd12, 6'd63, 4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R12
        '{OP_RD,  4'd12, 6'd63, 4'h0, 1'b0, 32'h0,         32'h0000_0000}, // R12
        '{OP_RD,  4'd12, 6'd4,  4'h0, 1'b0, 32'h0,         32'h1000_0008}, // R12
        '{OP_RD,  4'd12, 6'd1,  4'h0, 1'b0, 32'h0,         32'h0000_0002}, // R12
        '{OP_WR,  4'd11, 6'd12, 4'h1, 1'b0, 32'h0000_0001, 32'h0},         // R11
        '{OP_HIT, 4'd11, 6'd0,  4'h0, 1'b0, 32'h80A2_0010, 32'h8},         // R11
        '{OP_WR,  4'd8,  6'd1,  4'h2, 1'b0, 32'hFFFF_FF00, 32'h0},         // R8
        '{OP_RD,  4'd8,  6'd1,  4'h0, 1'b0, 32'h0,         32'h0000_0002}  // R8
    };

    logic        clk;
    logic        rst_n;
    logic        cfg_wr;
    logic [5:0]  cfg_idx;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] bus_addr;
    logic        bus_io_space;
    logic        hit_pref;
    logic        hit_io;
    logic        hit_np;
    logic        hit_rom;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pcibar_unit u_pcibar_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_idx      (cfg_idx),
        .cfg_be       (cfg_be),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .bus_addr     (bus_addr),
        .bus_io_space (bus_io_space),
        .hit_pref     (hit_pref),
        .hit_io       (hit_io),
        .hit_np       (hit_np),
        .hit_rom      (hit_rom)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = d;
        cfg_be    = be;
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_be    = 4'h0;
    endtask

    task automatic do_read(input int req, input logic [5:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #2;
        check(req, $sformatf("read idx %0d", idx), cfg_rdata, exp);
    endtask

    task automatic do_hit(input int req, input logic [31:0] a, input logic io,
                          input logic [3:0] exp);
        @(negedge clk);
        bus_addr     = a;
        bus_io_space = io;
        #2;
        check(req, $sformatf("hits for %08h io=%0d", a, io),
              {28'b0, hit_rom, hit_np, hit_io, hit_pref}, {28'b0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        cfg_wr       = 1'b0;
        cfg_idx      = 6'd0;
        cfg_be       = 4'h0;
        cfg_wdata    = 32'h0;
        bus_addr     = 32'h0;
        bus_io_space = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   do_write(VEC[i].idx, VEC[i].data, VEC[i].be);
                OP_RD:   do_read(int'(VEC[i].req), VEC[i].idx, VEC[i].exp);
                default: do_hit(int'(VEC[i].req), VEC[i].data, VEC[i].io, VEC[i].exp[3:0]);
            endcase
        end

        // R1: reset in the middle of a run returns every register to its type bits.
        @(negedge clk);
        rst_n = 1'b0;
        do_read(1, 6'd4, 32'h0000_0008);
        do_read(1, 6'd12, 32'h0000_0000);
        do_read(1, 6'd1, 32'h0000_0000);
        do_hit(1, 32'h0000_0000, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(1, 6'd6, 32'h0000_0000);
        do_read(1, 6'd5, 32'h0000_0001);
        do_hit(1, 32'h0000_0000, 1'b1, 4'h0);

        // R7: a write with every byte enable low leaves the window unchanged.
        do_write(6'd4, 32'h2000_0000, 4'hF);
        do_write(6'd4, 32'hFFFF_FFFF, 4'h0);
        do_read(7, 6'd4, 32'h2000_0008);

        // R9: window at the top of the address space, last byte in it.
        do_write(6'd1, 32'h0000_0002, 4'h1);
        do_write(6'd4, 32'hF800_0000, 4'hF);
        do_hit(9, 32'hFFFF_FFFF, 1'b0, 4'h1);
        do_hit(9, 32'hF7FF_FFFF, 1'b0, 4'h0);

        finish_run();
    end

endmodule